// File: doc/BRIEF.md
# Daisy-Chain SPI Target Frame Decoder

This block is the serial target interface of one device in a chain of up to 63 identical devices. All devices share one chip-select line. The controller's output feeds the first device, each device's output feeds the next, and the last device's output returns to the controller. Every device repeats the bytes it receives one byte later. It adds its own status byte at the front of the stream, so the controller reads all fault states without issuing a read command.

The device works out its position in the chain from the status bytes that reach it ahead of the first header byte. The header gives the chain length. From the two it knows which address byte and which data byte are its own. It holds the addressed register on a small register-file port. In the outgoing stream it puts that register's contents in place of its own address byte, so the controller finds the reports after the returned headers. A write is issued when chip select rises, and only for a well-formed frame. A clear-fault bit in the header produces a one-cycle pulse at the same moment.

The serial inputs pass through two-flop synchronizers into the system clock, which must run well above the serial clock. Bytes move most significant bit first. Input data is sampled on the serial clock rising edge and the output changes on the falling edge.

Top module: `spi_chain_target`

## Requirements
- R1: Apart from the slots named in R2 and R5, output byte k of a frame (counted from 0) equals input byte k-1, bit for bit, sent MSB first. Input is sampled on the serial clock rising edge and the output changes on the falling edge. The output is 0 while chip select is high.
- R2: The first output byte of every frame is the status byte. It is {1,1, fault_flags[5:0]}, with fault_flags taken when chip select falls.
- R3: The device's position P is the number of bytes with bits 7:6 = 11 received before the first byte with bits 7:6 = 10. That first header byte is {1,0, N[5:0]}, where N is the chain length, 1 to 63. Position and length decide the slots even for a 63-device chain.
- R4: Counting input bytes from 0, the device's address byte is input byte N+1 and its data byte is input byte 2N+1. The address byte has bit 7 = 0, bit 6 = 1 for a read or 0 for a write, and bits 5:0 = the register address, which is driven on reg_addr.
- R5: Output byte N+2 carries reg_rdata for the captured address in place of the forwarded address byte.
- R6: When chip select rises, reg_we pulses for one cycle with the captured address and data, if all of these hold: the frame held exactly 2N+2 whole bytes, the address byte is a write, and P < N.
- R7: A frame with any other byte count, or with a partial byte, produces no write.
- R8: The second header byte also needs bits 7:6 = 10. If it does not, or if a byte before the first header is neither a status byte nor a header byte, the frame is aborted. An aborted frame gives no write, no clear pulse and no report substitution, and its bytes are still forwarded under R1.
- R9: Bit 5 of the second header byte is the clear-fault request. clear_fault pulses for one cycle when chip select rises, once both header bytes are valid. Bits 4:0 of that byte are forwarded unchanged.
- R10: If N = 0 or P >= N, the device captures nothing, substitutes nothing and writes nothing. It only forwards bytes.
- R11: A read address byte produces the report of R5 and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Shared chip select, active low |
| spi_mosi | input | 1 | Serial data in from the upstream device or the controller |
| spi_miso | output | 1 | Serial data out toward the downstream device or the controller |
| fault_flags | input | 6 | Fault flags placed in the status byte |
| reg_rdata | input | 8 | Register contents at reg_addr, combinational from the register file |
| reg_addr | output | 6 | Register address from the captured address byte |
| reg_wdata | output | 8 | Captured data byte |
| reg_we | output | 1 | One-cycle write strobe |
| clear_fault | output | 1 | One-cycle global clear-fault pulse |

## Verification
The assertions assume the serial inputs change slowly compared with the system clock. Each serial clock phase and each chip-select idle gap must last several system cycles. They also assume chip select never moves in the same system cycle as a serial clock edge. Under these conditions a write or clear pulse can follow only a detected chip-select rise, a report selection can follow only a completed byte, and the status MSB is on the output one cycle after a frame opens. The stimulus keeps each serial clock phase at eight system cycles and waits ten cycles after chip select falls and twenty after it rises. It also places every serial edge between system clock edges.

// File: rtl/spi_dc_pkg.sv
package spi_dc_pkg;

  typedef enum logic [1:0] {
    ST_STAT  = 2'd0,
    ST_HDR2  = 2'd1,
    ST_BODY  = 2'd2,
    ST_ABORT = 2'd3
  } dc_state_e;

  function automatic logic is_status(input logic [7:0] b);
    return b[7:6] == 2'b11;
  endfunction

  function automatic logic is_header(input logic [7:0] b);
    return b[7:6] == 2'b10;
  endfunction

  // input byte index (from frame start) of this device's address byte
  function automatic int addr_slot(input int n);
    return n + 1;
  endfunction

  // input byte index of this device's data byte
  function automatic int data_slot(input int n);
    return 2 * n + 1;
  endfunction

  // whole bytes a well-formed frame carries
  function automatic int frame_bytes(input int n);
    return 2 * n + 2;
  endfunction

endpackage

// File: rtl/dc_sync.sv
module dc_sync #(
  parameter int            W   = 1,
  parameter logic [W-1:0]  RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST;
      s2 <= RST;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/dc_shifter.sv
module dc_shifter #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          mosi_s,
  input  logic          cs_n_s,
  input  logic [BW-1:0] status_byte,
  input  logic [BW-1:0] tx_next,
  output logic          frame_start,
  output logic          frame_end,
  output logic          byte_done,
  output logic [BW-1:0] rx_byte,
  output logic          aligned,
  output logic          miso
);
  localparam int BC_W = $clog2(BW);

  logic            sclk_d, cs_d, pend;
  logic [BW-1:0]   in_sr, out_sr;
  logic [BC_W-1:0] bit_cnt;
  logic            rise, fall, active;

  assign rise        = sclk_s & ~sclk_d;
  assign fall        = ~sclk_s & sclk_d;
  assign active      = ~cs_n_s;
  assign frame_start = cs_d & ~cs_n_s;
  assign frame_end   = ~cs_d & cs_n_s;
  assign aligned     = (bit_cnt == '0);
  assign miso        = active & out_sr[BW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      cs_d      <= 1'b1;
      pend      <= 1'b0;
      in_sr     <= '0;
      out_sr    <= '0;
      bit_cnt   <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      cs_d      <= cs_n_s;
      byte_done <= 1'b0;
      if (frame_start) begin
        out_sr  <= status_byte;
        bit_cnt <= '0;
        pend    <= 1'b0;
      end else if (frame_end) begin
        out_sr  <= '0;
        pend    <= 1'b0;
      end else if (active) begin
        if (rise) begin
          in_sr <= {in_sr[BW-2:0], mosi_s};
          if (bit_cnt == BC_W'(BW - 1)) begin
            bit_cnt   <= '0;
            rx_byte   <= {in_sr[BW-2:0], mosi_s};
            byte_done <= 1'b1;
            pend      <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end else if (fall) begin
          if (pend) begin
            out_sr <= tx_next;
            pend   <= 1'b0;
          end else begin
            out_sr <= {out_sr[BW-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/dc_decoder.sv
module dc_decoder
  import spi_dc_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          frame_end,
  input  logic          byte_done,
  input  logic [BW-1:0] rx_byte,
  input  logic          aligned,
  output logic          sub_sel,
  output logic [BW-3:0] reg_addr,
  output logic [BW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          clear_fault
);
  localparam int FW    = BW - 2;
  localparam int CNT_W = FW + 2;

  dc_state_e        state;
  logic [FW-1:0]    pos, n_dev;
  logic             mine, clr;
  logic [CNT_W-1:0] idx;
  logic [BW-1:0]    addr_b;
  logic             is_write;

  assign reg_addr  = addr_b[FW-1:0];
  assign is_write  = (addr_b[BW-1:BW-2] == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_STAT;
      pos         <= '0;
      n_dev       <= '0;
      mine        <= 1'b0;
      clr         <= 1'b0;
      idx         <= '0;
      addr_b      <= '0;
      reg_wdata   <= '0;
      sub_sel     <= 1'b0;
      reg_we      <= 1'b0;
      clear_fault <= 1'b0;
    end else begin
      reg_we      <= 1'b0;
      clear_fault <= 1'b0;
      if (frame_start) begin
        state   <= ST_STAT;
        pos     <= '0;
        n_dev   <= '0;
        mine    <= 1'b0;
        clr     <= 1'b0;
        idx     <= '0;
        sub_sel <= 1'b0;
      end else if (frame_end) begin
        sub_sel <= 1'b0;
        if (state == ST_BODY) begin
          clear_fault <= clr;
          if (mine && aligned && is_write &&
              idx == CNT_W'(frame_bytes(int'(n_dev))))
            reg_we <= 1'b1;
        end
      end else if (byte_done) begin
        if (idx != '1) idx <= idx + 1'b1;
        sub_sel <= 1'b0;
        case (state)
          ST_STAT: begin
            if (is_status(rx_byte)) begin
              if (pos == '1) state <= ST_ABORT;
              else           pos   <= pos + 1'b1;
            end else if (is_header(rx_byte)) begin
              n_dev <= rx_byte[FW-1:0];
              mine  <= (rx_byte[FW-1:0] != '0) && (pos < rx_byte[FW-1:0]);
              state <= ST_HDR2;
            end else begin
              state <= ST_ABORT;
            end
          end
          ST_HDR2: begin
            if (is_header(rx_byte)) begin
              clr   <= rx_byte[FW-1];
              state <= ST_BODY;
            end else begin
              state <= ST_ABORT;
            end
          end
          ST_BODY: begin
            if (mine && idx == CNT_W'(addr_slot(int'(n_dev)))) begin
              addr_b  <= rx_byte;
              sub_sel <= 1'b1;
            end
            if (mine && idx == CNT_W'(data_slot(int'(n_dev))))
              reg_wdata <= rx_byte;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_chain_target.sv
module spi_chain_target #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  input  logic [BW-3:0] fault_flags,
  input  logic [BW-1:0] reg_rdata,
  output logic [BW-3:0] reg_addr,
  output logic [BW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          clear_fault
);
  logic          cs_n_s, sclk_s, mosi_s;
  logic          frame_start, frame_end, byte_done, aligned, sub_sel;
  logic [BW-1:0] rx_byte, tx_next, status_byte;

  dc_sync #(.W(3), .RST(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_cs_n, spi_sclk, spi_mosi}),
    .q     ({cs_n_s, sclk_s, mosi_s})
  );

  assign status_byte = {2'b11, fault_flags};
  assign tx_next     = sub_sel ? reg_rdata : rx_byte;

  dc_shifter #(.BW(BW)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_s      (sclk_s),
    .mosi_s      (mosi_s),
    .cs_n_s      (cs_n_s),
    .status_byte (status_byte),
    .tx_next     (tx_next),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .byte_done   (byte_done),
    .rx_byte     (rx_byte),
    .aligned     (aligned),
    .miso        (spi_miso)
  );

  dc_decoder #(.BW(BW)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .byte_done   (byte_done),
    .rx_byte     (rx_byte),
    .aligned     (aligned),
    .sub_sel     (sub_sel),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_we      (reg_we),
    .clear_fault (clear_fault)
  );
endmodule

// File: rtl/spi_chain_target_chk.sv
module spi_chain_target_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_miso,
  input logic          reg_we,
  input logic          clear_fault,
  input logic [BW-3:0] reg_addr,
  input logic          frame_start,
  input logic          frame_end,
  input logic          byte_done,
  input logic          sub_sel
);
  // R6: a write only follows a detected chip-select rise
  p_we_after_cs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(frame_end));

  // R6: the strobe lasts one cycle
  p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R9: clear pulse only follows a chip-select rise
  p_clear_after_cs_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_fault |-> $past(frame_end));

  // R2: status MSB is on the output right after the frame opens
  p_status_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> spi_miso);

  // R4: the address changes only after a completed byte
  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(reg_addr));

  // R5: report selection starts only after a completed byte
  p_sub_after_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sub_sel) |-> $past(byte_done));
endmodule

bind spi_chain_target spi_chain_target_chk #(.BW(BW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_miso    (spi_miso),
  .reg_we      (reg_we),
  .clear_fault (clear_fault),
  .reg_addr    (reg_addr),
  .frame_start (frame_start),
  .frame_end   (frame_end),
  .byte_done   (byte_done),
  .sub_sel     (sub_sel)
);

// File: tb/spi_chain_target_bench.sv
module spi_chain_target_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       miso;
  logic [5:0] flags = '0;
  logic [7:0] rdata, wdata;
  logic [5:0] raddr;
  logic       we, clrf;

  logic [7:0] regmodel [64];
  int we_cnt = 0, clr_cnt = 0;
  int n_checks = 0, n_fail = 0;

  spi_chain_target u_spi_chain_target (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .fault_flags(flags),
    .reg_rdata(rdata), .reg_addr(raddr), .reg_wdata(wdata),
    .reg_we(we), .clear_fault(clrf)
  );

  assign rdata = regmodel[raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) regmodel[i] <= 8'(i * 3 + 1);
    end else if (we) begin
      regmodel[raddr] <= wdata;
    end
  end

  always @(posedge clk) begin
    if (we)   we_cnt  <= we_cnt + 1;
    if (clrf) clr_cnt <= clr_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard: driver pushes expected output bytes, monitor pops and compares
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] mon_sr = '0;
  int         mon_bits = 0;

  always @(posedge sclk or negedge cs_n) begin
    if (!cs_n && sclk) begin
      mon_sr = {mon_sr[6:0], miso};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_bits = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected byte", 32'(mon_sr), 32'h0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(mon_sr == e, t, 32'(mon_sr), 32'(e));
        end
      end
    end else if (!cs_n) begin
      mon_bits = 0;
    end
  end

  logic [7:0] fb [0:159];

  task automatic fill(input int pos, input int n, input logic [7:0] h1, input logic [7:0] h2,
                      input logic [7:0] a, input logic [7:0] d, input int len);
    for (int i = 0; i < len; i++) fb[i] = 8'h5A ^ 8'(i * 7);
    for (int i = 0; i < pos; i++) fb[i] = 8'hC0 | 8'(i & 63);
    fb[pos]     = h1;
    fb[pos + 1] = h2;
    if (n + 1 >= pos + 2 && n + 1 < len)     fb[n + 1] = a;
    if (2 * n + 1 >= pos + 2 && 2 * n + 1 < len) fb[2 * n + 1] = d;
  endtask

  task automatic run_frame(input int len, input int extra, input logic [5:0] fl, input int sub_slot,
                           input logic [5:0] sub_addr, input int exp_we, input logic [5:0] wa,
                           input logic [7:0] wd, input int exp_clr, input string wtag);
    int we0, clr0;
    flags = fl;
    exp_q.push_back({2'b11, fl});
    tag_q.push_back("R2 status byte");
    for (int k = 1; k < len; k++) begin
      if (k == sub_slot) begin
        exp_q.push_back(regmodel[sub_addr]);
        tag_q.push_back("R5 report slot");
      end else begin
        exp_q.push_back(fb[k - 1]);
        tag_q.push_back("R1 forwarded byte");
      end
    end
    we0 = we_cnt;
    clr0 = clr_cnt;
    cs_n = 1'b0;
    #100;
    for (int i = 0; i < len; i++) begin
      for (int b = 7; b >= 0; b--) begin
        mosi = fb[i][b];
        #80 sclk = 1'b1;
        #80 sclk = 1'b0;
      end
    end
    for (int b = 0; b < extra; b++) begin
      mosi = 1'b1;
      #80 sclk = 1'b1;
      #80 sclk = 1'b0;
    end
    #100 cs_n = 1'b1;
    #200;
    check(exp_q.size() == 0, "R1 all bytes returned", 32'(exp_q.size()), 32'h0);
    exp_q.delete();
    tag_q.delete();
    check((we_cnt - we0) == exp_we, wtag, 32'(we_cnt - we0), 32'(exp_we));
    if (exp_we != 0)
      check(regmodel[wa] == wd, {wtag, " written value"}, 32'(regmodel[wa]), 32'(wd));
    check((clr_cnt - clr0) == exp_clr, "R9 clear pulses", 32'(clr_cnt - clr0), 32'(exp_clr));
  endtask

  initial begin
    #2000000;
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #3;
    #40 rst_n = 1'b1;
    #60;
    check(miso == 1'b0, "R1 output low out of reset", 32'(miso), 32'h0);
    check(we == 1'b0 && clrf == 1'b0, "R6 no strobe out of reset", 32'({we, clrf}), 32'h0);

    // R6 single device, write reg 5 = A5
    fill(0, 1, 8'h81, 8'h95, 8'h05, 8'hA5, 4);
    run_frame(4, 0, 6'h2A, 3, 6'h05, 1, 6'h05, 8'hA5, 0, "R6 write N=1");

    // R11 read reg 5 from position 1 of 3, report shows A5
    fill(1, 3, 8'h83, 8'h9F, 8'h45, 8'h77, 8);
    run_frame(8, 0, 6'h15, 5, 6'h05, 0, 6'h05, 8'h00, 0, "R11 read no write");

    // R4 position 2 of 4, write reg 63 with clear request
    fill(2, 4, 8'h84, 8'hA3, 8'h3F, 8'h5C, 10);
    run_frame(10, 0, 6'h3F, 6, 6'h3F, 1, 6'h3F, 8'h5C, 1, "R4 write slot N=4");

    // R7 same frame one byte short
    fill(2, 4, 8'h84, 8'hA3, 8'h3F, 8'h11, 9);
    run_frame(9, 0, 6'h00, 6, 6'h3F, 0, 6'h3F, 8'h00, 1, "R7 short frame");

    // R7 partial trailing byte
    fill(0, 1, 8'h81, 8'h80, 8'h05, 8'h22, 4);
    run_frame(4, 3, 6'h01, 3, 6'h05, 0, 6'h05, 8'h00, 0, "R7 partial byte");

    // R8 bad first header after a status byte
    fill(1, 2, 8'h42, 8'hA0, 8'h05, 8'h33, 6);
    run_frame(6, 0, 6'h0C, -1, 6'h00, 0, 6'h00, 8'h00, 0, "R8 bad first header");

    // R8 bad second header
    fill(0, 2, 8'h82, 8'hE0, 8'h05, 8'h33, 6);
    run_frame(6, 0, 6'h30, -1, 6'h00, 0, 6'h00, 8'h00, 0, "R8 bad second header");

    // R10 position beyond chain length, clear still honoured
    fill(2, 2, 8'h82, 8'hA0, 8'h05, 8'h33, 6);
    run_frame(6, 0, 6'h07, -1, 6'h00, 0, 6'h00, 8'h00, 1, "R10 position out of range");

    // R10 zero-length chain
    fill(0, 0, 8'h80, 8'h80, 8'h00, 8'h00, 2);
    run_frame(2, 0, 6'h21, -1, 6'h00, 0, 6'h00, 8'h00, 0, "R10 zero devices");

    // R3 63-device chain, position 62, write reg 10 = 3C
    fill(62, 63, 8'hBF, 8'h80, 8'h0A, 8'h3C, 128);
    run_frame(128, 0, 6'h12, 65, 6'h0A, 1, 6'h0A, 8'h3C, 0, "R3 63-device chain");

    // R5 read back reg 10 via report
    fill(0, 2, 8'h82, 8'h80, 8'h4A, 8'h00, 6);
    run_frame(6, 0, 6'h00, 4, 6'h0A, 0, 6'h0A, 8'h00, 0, "R5 report read");
    check(regmodel[10] == 8'h3C, "R5 register kept", 32'(regmodel[10]), 32'h3C);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule